// File: doc/BRIEF.md
# Bytecode Instruction Byte Fetcher

This block feeds an instruction interpreter with one 8-bit opcode at a time. It reads 16-bit words from a word-addressed memory. Each word carries two opcodes: the high byte comes first and the low byte second. The block keeps a word program counter and a one-byte holder. The holder keeps the second byte of the current word, right-justified, until the interpreter asks for it. A holder value of zero means no byte is pending. An entry that asks for the held byte while the holder is zero therefore starts a fresh word fetch.

The interpreter drives an entry request. The entry can ask for the held byte, a fetch of the next word, a fetch from a computed jump address, or a fetch of only the low byte of a word (used for jumps to an odd byte). Some fetch entries check the pending-interrupt input against a wakeup-disable counter. When an interrupt is taken, the block dispatches no opcode and pulses a stop output. That output tells the interpreter whether it stopped on an even or an odd byte. For an even byte, the program counter is stepped back so that a resume fetches the same word again. Deaf variants fetch the same way but never look at the interrupt input.

Top module: `byte_fetch_unit`

## Requirements
- R1: After reset, `pc` is 0, `ready` is 1, and `mem_rd_en`, `op_valid` and `intr_stop` are 0. The holder is empty, so a held-byte entry (kind 0) right after reset starts a fetch of word 1.
- R2: A request is accepted at a rising edge where `ready` and `req_valid` are both 1. A next-word entry (kind 1 listening, kind 2 deaf) reads address `pc+1` and makes that address the new `pc`. `mem_rd_en` is high for exactly the first cycle after the accepting edge. `mem_rdata` is taken in the second cycle. `op_valid` pulses in the third cycle and carries the high byte (bits 15:8) of the word.
- R3: A word fetched for its high byte leaves its low byte (bits 7:0) in the holder. A held-byte entry (kind 0) with a non-zero holder needs no memory read. It presents the held byte with `op_valid` in the first cycle after the accepting edge and leaves the holder empty.
- R4: A held-byte entry (kind 0) with an empty holder behaves exactly like the listening next-word entry (kind 1). This includes the interrupt check. A low byte of zero is therefore never dispatched from the holder.
- R5: An odd-byte entry (kind 3 listening, kind 4 deaf) reads the word at `req_target` and sets `pc` to `req_target`. It dispatches only the low byte, with the R2 timing, and leaves the holder empty.
- R6: A jump entry (kind 5, listening) sets `pc` to `req_target`, reads that word, dispatches its high byte and keeps its low byte in the holder.
- R7: A listening entry takes an interrupt when `irq_pending` is 1 and `wake_cnt` is 0 at the accepting edge. The read still happens, but `op_valid` stays 0. Instead, `intr_stop` pulses for one cycle in the cycle where the opcode would have appeared.
- R8: An interrupt taken on a high-byte fetch (kinds 0, 1, 5) reports `intr_odd` = 0, empties the holder and leaves `pc` one below the fetched address, modulo 2^16.
- R9: An interrupt taken on an odd-byte entry (kind 3) reports `intr_odd` = 1. It leaves `pc` at `req_target` and keeps the fetched low byte in the holder.
- R10: `irq_pending` has no effect when `wake_cnt` is non-zero. It also has no effect on the deaf kinds 2 and 4.
- R11: While `ready` is 0, `req_valid` is ignored. Kinds 6 and 7 are ignored entirely: no read, no opcode, and `pc` and the holder are unchanged.
- R12: `op_valid` and `intr_stop` are never high together. Each fetch produces exactly one single-cycle `mem_rd_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Entry request strobe |
| req_kind | input | 3 | Entry kind: 0 held byte, 1 next word, 2 next word deaf, 3 odd byte, 4 odd byte deaf, 5 jump |
| req_target | input | 16 | Word address for kinds 3, 4, 5 |
| ready | output | 1 | Block idle, request can be accepted |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |
| irq_pending | input | 1 | Interrupt pending |
| wake_cnt | input | 4 | Wakeup-disable counter; interrupts only when zero |
| op_valid | output | 1 | Opcode strobe, one cycle |
| op_byte | output | 8 | Dispatched opcode |
| intr_stop | output | 1 | Interrupt taken, one-cycle pulse |
| intr_odd | output | 1 | With `intr_stop`: 1 if stopped on an odd byte |
| pc | output | 16 | Word program counter |

## Verification
The result of a fetch and the interrupt decision fall in the same cycle. The read is issued anyway, and the returning word must turn into either an opcode or an interrupt stop, never both. This is provoked in two ways. Random stimulus sets `irq_pending` and a small `wake_cnt` on every entry kind. Directed cases then put an interrupt on a jump to address 0, an interrupt on an odd-byte entry, and a held-byte entry whose holder is empty. A bench model predicts each outcome. For each case the bench compares the opcode or stop pulse, the `intr_odd` flag, the resulting `pc` and the holder's effect on the next entry.

// File: rtl/bfu_pkg.sv
// Shared types for the byte fetch unit.
package bfu_pkg;

    // Entry kinds; numeric codes are part of the port contract
    typedef enum logic [2:0] {
        ENT_HELD      = 3'd0,
        ENT_NEXT      = 3'd1,
        ENT_NEXT_DEAF = 3'd2,
        ENT_ODD       = 3'd3,
        ENT_ODD_DEAF  = 3'd4,
        ENT_JUMP      = 3'd5
    } entry_t;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fetch_state_t;

endpackage

// File: rtl/bfu_decode.sv
// Entry decoder: classifies the requested entry kind.
// Assumes kind codes as defined in bfu_pkg; codes above ENT_JUMP are invalid.
module bfu_decode
    import bfu_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       hold_empty,
    output logic       kind_ok,
    output logic       use_held,
    output logic       odd_only,
    output logic       use_target,
    output logic       listen
);

    entry_t k;

    // Classify the entry kind into fetch attributes
    always_comb begin
        k          = entry_t'(kind);
        kind_ok    = (kind <= 3'd5);
        use_held   = (k == ENT_HELD) && !hold_empty;
        odd_only   = (k == ENT_ODD) || (k == ENT_ODD_DEAF);
        use_target = (k == ENT_ODD) || (k == ENT_ODD_DEAF) || (k == ENT_JUMP);
        listen     = (k == ENT_HELD) || (k == ENT_NEXT) ||
                     (k == ENT_ODD)  || (k == ENT_JUMP);
    end

endmodule

// File: rtl/bfu_pc.sv
// Word program counter with step, load and step-back operations.
// Assumes at most one of step/load/back is active in a cycle.
module bfu_pc #(
    parameter int AW       = 16,
    parameter int PC_RESET = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          back,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pc_plus1
);

    localparam logic [AW-1:0] RST_VAL = AW'(PC_RESET);
    localparam logic [AW-1:0] ONE     = AW'(1);

    assign pc_plus1 = pc + ONE;

    // Update the program counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RST_VAL;
        else if (load)
            pc <= load_val;
        else if (step)
            pc <= pc_plus1;
        else if (back)
            pc <= pc - ONE;
    end

    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (pc == $past(pc) + ONE));

    // R8
    back_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (back && !load && !step) |=> (pc == $past(pc) - ONE));

    // R12
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({step, load, back}) <= 1);

endmodule

// File: rtl/bfu_hold.sv
// One-byte holder for the pending second opcode; zero means empty.
// Assumes a single write port driven by the controller.
module bfu_hold #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] wd,
    output logic [BW-1:0] hold,
    output logic          empty
);

    assign empty = (hold == '0);

    // Store a new holder value
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (we)
            hold <= wd;
    end

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wd == '0) |=> empty);

endmodule

// File: rtl/bfu_ctrl.sv
// Fetch controller: accepts entries, issues the memory read, splits the
// returned word into opcode and held byte, and decides interrupt stops.
// Assumes memory read data arrives one cycle after mem_rd_en.
module bfu_ctrl
    import bfu_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_target,
    input  logic            kind_ok,
    input  logic            use_held,
    input  logic            odd_only,
    input  logic            use_target,
    input  logic            listen,
    input  logic            irq_pending,
    input  logic [CW-1:0]   wake_cnt,
    input  logic [AW-1:0]   pc_plus1,
    input  logic [BW-1:0]   hold,
    input  logic [2*BW-1:0] mem_rdata,
    output logic            ready,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_addr,
    output logic            pc_step,
    output logic            pc_load,
    output logic            pc_back,
    output logic            hold_we,
    output logic [BW-1:0]   hold_wd,
    output logic            op_valid,
    output logic [BW-1:0]   op_byte,
    output logic            intr_stop,
    output logic            intr_odd
);

    fetch_state_t  state;
    logic          accept;
    logic          fetch_go;
    logic          take_now;
    logic          odd_q;
    logic          take_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] hi_byte;
    logic [BW-1:0] lo_byte;

    assign ready     = (state == ST_IDLE);
    assign accept    = ready && req_valid && kind_ok;
    assign fetch_go  = accept && !use_held;
    assign take_now  = listen && irq_pending && (wake_cnt == '0);
    assign mem_rd_en = (state == ST_ISSUE);
    assign mem_addr  = addr_q;
    assign hi_byte   = mem_rdata[2*BW-1:BW];
    assign lo_byte   = mem_rdata[BW-1:0];

    assign pc_step = fetch_go && !use_target;
    assign pc_load = fetch_go && use_target;
    assign pc_back = (state == ST_WAIT) && take_q && !odd_q;

    // Holder write: cleared on held dispatch, refilled when a word returns
    always_comb begin
        hold_we = 1'b0;
        hold_wd = '0;
        if (accept && use_held) begin
            hold_we = 1'b1;
        end else if (state == ST_WAIT) begin
            hold_we = 1'b1;
            if (take_q)
                hold_wd = odd_q ? lo_byte : '0;
            else
                hold_wd = odd_q ? '0 : lo_byte;
        end
    end

    // Sequence the fetch: idle, issue read, wait for data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            odd_q  <= 1'b0;
            take_q <= 1'b0;
            addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fetch_go) begin
                        state  <= ST_ISSUE;
                        odd_q  <= odd_only;
                        take_q <= take_now;
                        addr_q <= use_target ? req_target : pc_plus1;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Register the opcode and interrupt-stop outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid  <= 1'b0;
            op_byte   <= '0;
            intr_stop <= 1'b0;
            intr_odd  <= 1'b0;
        end else begin
            op_valid  <= 1'b0;
            intr_stop <= 1'b0;
            if (accept && use_held) begin
                op_valid <= 1'b1;
                op_byte  <= hold;
            end else if (state == ST_WAIT) begin
                if (take_q) begin
                    intr_stop <= 1'b1;
                    intr_odd  <= odd_q;
                end else begin
                    op_valid <= 1'b1;
                    op_byte  <= odd_q ? lo_byte : hi_byte;
                end
            end
        end
    end

    // R12
    op_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && intr_stop));

    // R12
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R2
    read_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 (op_valid || intr_stop));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !ready);

    // R7
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_stop |=> !intr_stop);

endmodule

// File: rtl/byte_fetch_unit.sv
// Top of the bytecode byte fetcher: ties decoder, program counter,
// byte holder and fetch controller together.
// Assumes a word memory with one cycle of read latency.
module byte_fetch_unit #(
    parameter int AW       = 16,
    parameter int BW       = 8,
    parameter int CW       = 4,
    parameter int PC_RESET = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [AW-1:0]   req_target,
    output logic            ready,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_addr,
    input  logic [2*BW-1:0] mem_rdata,
    input  logic            irq_pending,
    input  logic [CW-1:0]   wake_cnt,
    output logic            op_valid,
    output logic [BW-1:0]   op_byte,
    output logic            intr_stop,
    output logic            intr_odd,
    output logic [AW-1:0]   pc
);

    logic          kind_ok, use_held, odd_only, use_target, listen;
    logic          hold_empty, hold_we;
    logic [BW-1:0] hold, hold_wd;
    logic          pc_step, pc_load, pc_back;
    logic [AW-1:0] pc_plus1;

    bfu_decode u_dec (
        .kind       (req_kind),
        .hold_empty (hold_empty),
        .kind_ok    (kind_ok),
        .use_held   (use_held),
        .odd_only   (odd_only),
        .use_target (use_target),
        .listen     (listen)
    );

    bfu_pc #(.AW(AW), .PC_RESET(PC_RESET)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (pc_step),
        .load     (pc_load),
        .load_val (req_target),
        .back     (pc_back),
        .pc       (pc),
        .pc_plus1 (pc_plus1)
    );

    bfu_hold #(.BW(BW)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hold_we),
        .wd    (hold_wd),
        .hold  (hold),
        .empty (hold_empty)
    );

    bfu_ctrl #(.AW(AW), .BW(BW), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_target  (req_target),
        .kind_ok     (kind_ok),
        .use_held    (use_held),
        .odd_only    (odd_only),
        .use_target  (use_target),
        .listen      (listen),
        .irq_pending (irq_pending),
        .wake_cnt    (wake_cnt),
        .pc_plus1    (pc_plus1),
        .hold        (hold),
        .mem_rdata   (mem_rdata),
        .ready       (ready),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .pc_step     (pc_step),
        .pc_load     (pc_load),
        .pc_back     (pc_back),
        .hold_we     (hold_we),
        .hold_wd     (hold_wd),
        .op_valid    (op_valid),
        .op_byte     (op_byte),
        .intr_stop   (intr_stop),
        .intr_odd    (intr_odd)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (ready && !op_valid && !intr_stop && !mem_rd_en));

endmodule

// File: tb/tb_byte_fetch_unit.sv
// Self-checking bench for byte_fetch_unit: model-predicted outcomes for
// directed corner cases and seeded random entry sequences.
module tb_byte_fetch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_target = '0;
    logic        ready, mem_rd_en, op_valid, intr_stop, intr_odd;
    logic [15:0] mem_addr, pc;
    logic [15:0] mem_rdata = '0;
    logic        irq_pending = 1'b0;
    logic [3:0]  wake_cnt = '0;
    logic [7:0]  op_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    logic [15:0] m_pc = '0;
    logic [7:0]  m_hold = '0;

    always #4 clk = ~clk;

    byte_fetch_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_target(req_target), .ready(ready), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .irq_pending(irq_pending),
        .wake_cnt(wake_cnt), .op_valid(op_valid), .op_byte(op_byte),
        .intr_stop(intr_stop), .intr_odd(intr_odd), .pc(pc)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + 8'h33};
    endfunction

    // Memory with one cycle of read latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one entry and compare every observable against the model
    task automatic do_req(input logic [2:0] kind, input logic [15:0] tgt,
                          input logic irq, input logic [3:0] wc);
        logic        held, is_fetch, odd, listen, take;
        logic [15:0] addr, w;
        @(negedge clk);
        irq_pending = irq; wake_cnt = wc;
        req_kind = kind; req_target = tgt; req_valid = 1'b1;
        chk(ready == 1'b1, "R11 ready before request", ready, 1);
        held     = (kind == 3'd0) && (m_hold != 8'h00);
        is_fetch = (kind <= 3'd5) && !held;
        odd      = (kind == 3'd3) || (kind == 3'd4);
        listen   = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3) || (kind == 3'd5);
        take     = listen && irq && (wc == 4'd0);
        addr     = (kind == 3'd3 || kind == 3'd4 || kind == 3'd5) ? tgt : m_pc + 16'd1;
        @(negedge clk);
        if (held) begin
            req_valid = 1'b0;
            chk(op_valid && op_byte == m_hold, "R3 held byte dispatch", {op_valid, op_byte}, {1'b1, m_hold});
            chk(!mem_rd_en, "R3 no read for held byte", mem_rd_en, 0);
            m_hold = 8'h00;
        end else if (!is_fetch) begin
            req_valid = 1'b0;
            chk(!mem_rd_en && !op_valid && !intr_stop && ready, "R11 invalid kind ignored",
                {mem_rd_en, op_valid, intr_stop, ready}, 4'b0001);
            chk(pc == m_pc, "R11 pc untouched by invalid kind", pc, m_pc);
        end else begin
            // Garbage request while busy must be ignored (R11)
            req_kind = 3'd5; req_target = ~tgt;
            chk(mem_rd_en && mem_addr == addr, "R2 read strobe and address", {mem_rd_en, mem_addr}, {1'b1, addr});
            chk(!ready, "R11 busy during read", ready, 0);
            @(negedge clk);
            chk(!mem_rd_en && !op_valid && !intr_stop, "R12 single read pulse", {mem_rd_en, op_valid, intr_stop}, 0);
            @(negedge clk);
            req_valid = 1'b0;
            w = memf(addr);
            m_pc = addr;
            if (take) begin
                chk(intr_stop && !op_valid, "R7 interrupt stop instead of opcode", {intr_stop, op_valid}, 2'b10);
                chk(intr_odd == odd, odd ? "R9 odd stop position" : "R8 even stop position", intr_odd, odd);
                if (odd) m_hold = w[7:0];
                else begin m_pc = addr - 16'd1; m_hold = 8'h00; end
            end else begin
                chk(op_valid && !intr_stop, irq ? "R10 interrupt ignored" : "R2 opcode strobe",
                    {op_valid, intr_stop}, 2'b10);
                chk(op_byte == (odd ? w[7:0] : w[15:8]), odd ? "R5 odd byte opcode" : "R6 even byte opcode",
                    op_byte, odd ? w[7:0] : w[15:8]);
                m_hold = odd ? 8'h00 : w[7:0];
            end
            chk(pc == m_pc, "R8 program counter after fetch", pc, m_pc);
        end
        chk(!(op_valid && intr_stop), "R12 exclusive outputs", {op_valid, intr_stop}, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc == 16'd0 && ready && !op_valid && !intr_stop && !mem_rd_en, "R1 reset state",
            {pc, ready, op_valid, intr_stop, mem_rd_en}, {16'd0, 4'b1000});
        rst_n = 1'b1;
        // R1/R4: empty holder after reset makes kind 0 fetch word 1
        do_req(3'd0, 16'h0000, 1'b0, 4'd0);
        // R3: held low byte dispatched
        do_req(3'd0, 16'h0000, 1'b0, 4'd0);
        // R4: holder now empty, kind 0 fetches again with interrupt check
        do_req(3'd0, 16'h0000, 1'b1, 4'd0);
        // R6: jump, then R11 kinds 6 and 7 ignored
        do_req(3'd5, 16'h1234, 1'b0, 4'd0);
        do_req(3'd6, 16'h0000, 1'b0, 4'd0);
        do_req(3'd7, 16'h0000, 1'b0, 4'd0);
        do_req(3'd0, 16'h0000, 1'b0, 4'd0);
        // R8: interrupt on a jump to 0 wraps pc to FFFF
        do_req(3'd5, 16'h0000, 1'b1, 4'd0);
        // R10: counter non-zero and deaf kinds ignore the interrupt
        do_req(3'd1, 16'h0000, 1'b1, 4'd3);
        do_req(3'd2, 16'h0000, 1'b1, 4'd0);
        do_req(3'd4, 16'h0400, 1'b1, 4'd0);
        // R9: odd interrupt keeps low byte; resume dispatches it
        do_req(3'd3, 16'h0777, 1'b1, 4'd0);
        do_req(3'd0, 16'h0000, 1'b0, 4'd0);
        // R5: odd entry on a word whose low byte is zero; holder stays empty
        do_req(3'd3, 16'h00CD, 1'b0, 4'd0);
        do_req(3'd0, 16'h0000, 1'b0, 4'd0);
        // R4: even fetch of a zero low byte, then kind 0 refetches
        do_req(3'd5, 16'h00CD, 1'b0, 4'd0);
        do_req(3'd0, 16'h0000, 1'b0, 4'd0);
        // Random mix
        void'($urandom(32'd1977));
        for (int i = 0; i < 600; i++) begin
            logic [2:0] k;
            k = 3'($urandom % 8);
            do_req(k, 16'($urandom), ($urandom % 3) == 0, 4'($urandom % 3));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule